// File: doc/BRIEF.md
# Serial Configuration Port with Latch-on-Deselect

This block receives a 24-bit configuration word over a three-wire serial link made of a data line, a serial clock and an active-low select. The three serial lines are sampled with the system clock. While the select is low, every rising edge of the serial clock shifts one data bit into a holding shift register. The outputs of the block do not change during a transfer. The whole word moves into a shadow register only when the select returns high, and every decoded field is driven from that shadow copy.

The decoded fields control the motor driver around the port:

- a run/sleep enable
- a step-only test mode
- a brake request
- a two-bit current-limit code
- a fourteen-bit speed reference word
- a speed-source select
- a two-bit pole-count code
- a two-bit monitor select

The monitor select steers one of four live status inputs to a single monitor output. A synchronous active-low reset clears the shift register and the shadow register. After reset the run enable is low, so the driver sleeps.

Top module: `cfg_shift_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, the shift register and the shadow register are cleared. Every configuration output therefore reads 0, including `run_en` (0 = sleep).
- R2: While `ser_csn` is high, toggling `ser_clk` and `ser_din` leaves the shift register unchanged. A later select pulse with no clocks reloads the previous word.
- R3: Bits are taken on rising edges of `ser_clk` seen while `ser_csn` is low, with the first bit sent first. The first bit of a 24-clock frame lands in bit 23 and the last bit lands in bit 0.
- R4: The configuration outputs keep their previous values throughout a transfer. The new word appears only after `ser_csn` goes from low to high.
- R5: The field map of the word is fixed:
  - bit 0 → `run_en` (1 = run)
  - bit 1 → `step_only` (1 = step only)
  - bit 2 → `brake_on` (1 = brake)
  - bits 18..5 → `speed_word[13:0]`, with bit 5 as the least significant bit
  - bit 19 → `speed_src` (1 = external index)
- R6: The two-bit codes take their bits as {upper, lower}:
  - `ilim_code` = {bit 3, bit 4}, meaning 00 saturated, 01 1 A, 10 800 mA, 11 600 mA
  - `pole_code` = {bit 20, bit 21}
  - `mon_sel` = {bit 22, bit 23}
- R7: `mon_out` follows a status input, chosen by `mon_sel`:
  - 00 → `st_tach`
  - 01 → `st_therm`
  - 10 → `st_sync`
  - 11 → `st_zc`
- R8: A frame of other than 24 clocks is still latched. The shadow register receives the last 24 bits shifted in, across frame boundaries.
- R9: A reset during a transfer discards the partly shifted bits. A following empty select pulse latches all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_din | input | 1 | Serial data |
| ser_csn | input | 1 | Active-low select; its rising edge latches the word |
| st_tach | input | 1 | Status source: tachometer |
| st_therm | input | 1 | Status source: thermal shutdown |
| st_sync | input | 1 | Status source: sync |
| st_zc | input | 1 | Status source: zero-crossing flag |
| run_en | output | 1 | 1 = run, 0 = sleep |
| step_only | output | 1 | Step-only test mode |
| brake_on | output | 1 | Brake request |
| ilim_code | output | 2 | Current-limit code |
| speed_word | output | 14 | Speed reference word |
| speed_src | output | 1 | Speed source select |
| pole_code | output | 2 | Pole-count code |
| mon_sel | output | 2 | Monitor select |
| mon_out | output | 1 | Selected status signal |

## Verification
Each serial line passes two synchronizer stages and one edge-history flop. A rising edge of the select is therefore seen on the second system clock edge after it. The shadow register and all decoded outputs change on the third edge. `mon_out` is combinational from the shadow register and the status inputs, so it is valid as soon as both are settled.

The bench sets every serial line at least four system cycles apart. The driver pushes the expected word into the scoreboard queue eight cycles after the select rises. The monitor compares on a falling clock edge, well past the three-edge latency. Mid-frame hold checks sample while the select is still low.

// File: rtl/cfg_pkg.sv
// Package: frame width, field positions and the decoded configuration type.
// Assumes one frame holds a whole configuration word with bit 0 sent last.
package cfg_pkg;
    localparam int FRAME_W  = 24;
    localparam int SPEED_W  = 14;
    localparam int SPEED_LO = 5;
    localparam int SPEED_HI = SPEED_LO + SPEED_W - 1;

    typedef struct packed {
        logic [1:0]         mon_sel;
        logic [1:0]         pole;
        logic               speed_src;
        logic [SPEED_W-1:0] speed_word;
        logic [1:0]         ilim;
        logic               brake;
        logic               step;
        logic               run;
    } cfg_t;

    // Maps a raw frame onto named fields; each two-bit code is {lower index, higher index}.
    function automatic cfg_t decode_cfg(input logic [FRAME_W-1:0] w);
        cfg_t c;
        c.run        = w[0];
        c.step       = w[1];
        c.brake      = w[2];
        c.ilim       = {w[3], w[4]};
        c.speed_word = w[SPEED_HI:SPEED_LO];
        c.speed_src  = w[19];
        c.pole       = {w[20], w[21]};
        c.mon_sel    = {w[22], w[23]};
        return c;
    endfunction
endpackage

// File: rtl/cfg_sync.sv
// Synchronizer for the serial lines with edge detection.
// Assumes all three lines are slow relative to clk. The select chain resets
// to idle-high so that reset never creates a false latch edge.
module cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic csn_in,
    input  logic din_in,
    output logic sclk_rise,
    output logic csn_rise,
    output logic csn_s,
    output logic din_s
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] sclk_q, csn_q, din_q;
    logic          sclk_prev, csn_prev;

    // Shift each line through its synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= '0;
            csn_q  <= '1;
            din_q  <= '0;
        end else begin
            sclk_q[0] <= sclk_in;
            csn_q[0]  <= csn_in;
            din_q[0]  <= din_in;
            for (int i = 1; i < STAGES; i++) begin
                sclk_q[i] <= sclk_q[i-1];
                csn_q[i]  <= csn_q[i-1];
                din_q[i]  <= din_q[i-1];
            end
        end
    end

    // Keep last synchronized values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            csn_prev  <= 1'b1;
        end else begin
            sclk_prev <= sclk_q[LAST];
            csn_prev  <= csn_q[LAST];
        end
    end

    // Derive edge strobes and expose synchronized levels.
    always_comb begin
        sclk_rise = sclk_q[LAST] & ~sclk_prev;
        csn_rise  = csn_q[LAST] & ~csn_prev;
        csn_s     = csn_q[LAST];
        din_s     = din_q[LAST];
    end
endmodule

// File: rtl/cfg_shifter.sv
// Shift register that takes one bit per serial clock edge while selected.
// Assumes strobes from cfg_sync. It keeps no frame count, so the last
// FRAME_W bits received are always present.
module cfg_shifter
    import cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_rise,
    input  logic               csn_s,
    input  logic               din_s,
    output logic [FRAME_W-1:0] shift_q
);
    // Shift toward the top so the final bit lands in bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shift_q <= '0;
        else if (sclk_rise && !csn_s)
            shift_q <= {shift_q[FRAME_W-2:0], din_s};
    end
endmodule

// File: rtl/cfg_shadow.sv
// Shadow register loaded on deselect, plus field decode.
// Assumes csn_rise is a single-cycle strobe.
module cfg_shadow
    import cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csn_rise,
    input  logic [FRAME_W-1:0] shift_q,
    output logic [FRAME_W-1:0] shadow_q,
    output cfg_t               cfg
);
    // Capture the complete word when the select is released.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (csn_rise)
            shadow_q <= shift_q;
    end

    // Split the held word into named fields.
    always_comb cfg = decode_cfg(shadow_q);
endmodule

// File: rtl/mon_mux.sv
// Four-way status selector for the monitor output.
// Assumes the status inputs are already in the clk domain or are monitor-only.
module mon_mux #(
    parameter int N_SRC = 4,
    localparam int SEL_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] src,
    input  logic [SEL_W-1:0] sel,
    output logic             out
);
    // Route the chosen source to the output.
    always_comb out = src[sel];
endmodule

// File: rtl/cfg_shift_port.sv
// Top level of the serial configuration port.
// Assumes the serial lines change slower than a few clk periods and that
// the serial clock is low before the select falls.
module cfg_shift_port
    import cfg_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_clk,
    input  logic         ser_din,
    input  logic         ser_csn,
    input  logic         st_tach,
    input  logic         st_therm,
    input  logic         st_sync,
    input  logic         st_zc,
    output logic         run_en,
    output logic         step_only,
    output logic         brake_on,
    output logic [1:0]   ilim_code,
    output logic [13:0]  speed_word,
    output logic         speed_src,
    output logic [1:0]   pole_code,
    output logic [1:0]   mon_sel,
    output logic         mon_out
);
    logic               sclk_rise, csn_rise, csn_s, din_s;
    logic [FRAME_W-1:0] shift_q, shadow_q;
    cfg_t               cfg_q;

    cfg_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sclk_in(ser_clk), .csn_in(ser_csn), .din_in(ser_din),
        .sclk_rise(sclk_rise), .csn_rise(csn_rise),
        .csn_s(csn_s), .din_s(din_s)
    );

    cfg_shifter u_shift (
        .clk(clk), .rst_n(rst_n),
        .sclk_rise(sclk_rise), .csn_s(csn_s), .din_s(din_s),
        .shift_q(shift_q)
    );

    cfg_shadow u_shadow (
        .clk(clk), .rst_n(rst_n),
        .csn_rise(csn_rise), .shift_q(shift_q),
        .shadow_q(shadow_q), .cfg(cfg_q)
    );

    mon_mux #(.N_SRC(4)) u_mux (
        .src({st_zc, st_sync, st_therm, st_tach}),
        .sel(cfg_q.mon_sel),
        .out(mon_out)
    );

    // Drive the decoded fields onto the ports.
    always_comb begin
        run_en     = cfg_q.run;
        step_only  = cfg_q.step;
        brake_on   = cfg_q.brake;
        ilim_code  = cfg_q.ilim;
        speed_word = cfg_q.speed_word;
        speed_src  = cfg_q.speed_src;
        pole_code  = cfg_q.pole;
        mon_sel    = cfg_q.mon_sel;
    end
endmodule

// File: rtl/cfg_shift_port_chk.sv
// Checker for cfg_shift_port, attached with bind. It watches the internal
// strobes and registers against the port behaviour.
module cfg_shift_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        csn_s,
    input logic        csn_rise,
    input logic [23:0] shift_q,
    input logic [23:0] shadow_q,
    input logic        run_en,
    input logic [13:0] speed_word,
    input logic [1:0]  mon_sel,
    input logic        mon_out,
    input logic        st_tach,
    input logic        st_therm,
    input logic        st_sync,
    input logic        st_zc
);
    logic rst_seen = 1'b0;
    logic rst_q    = 1'b1;

    // Remember the reset level of the previous edge.
    always_ff @(posedge clk) begin
        rst_seen <= 1'b1;
        rst_q    <= rst_n;
    end

    // R1: one edge after reset is seen, the state is clear.
    always_ff @(posedge clk) begin
        if (rst_seen && !rst_q)
            p_reset_clear_r1: assert (shadow_q == '0 && shift_q == '0 && !run_en)
                else $error("reset did not clear");
    end

    // R2: no shift while deselected.
    p_ignore_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> $stable(shift_q));

    // R3: on deselect the shadow register takes the shift register contents.
    p_load_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        csn_rise |=> shadow_q == $past(shift_q));

    // R4: without a deselect edge the outputs hold.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !csn_rise |=> $stable(shadow_q) && $stable(speed_word));

    // R7: each select code routes its own source.
    p_mux_tach_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mon_sel == 2'b00 |-> mon_out == st_tach);
    p_mux_therm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mon_sel == 2'b01 |-> mon_out == st_therm);
    p_mux_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mon_sel == 2'b10 |-> mon_out == st_sync);
    p_mux_zc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mon_sel == 2'b11 |-> mon_out == st_zc);
endmodule

bind cfg_shift_port cfg_shift_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .csn_rise(csn_rise),
    .shift_q(shift_q), .shadow_q(shadow_q), .run_en(run_en),
    .speed_word(speed_word), .mon_sel(mon_sel), .mon_out(mon_out),
    .st_tach(st_tach), .st_therm(st_therm), .st_sync(st_sync), .st_zc(st_zc)
);

// File: tb/tb_cfg_shift_port.sv
// Scoreboard bench: the driver queues expected words and the monitor compares them.
module tb_cfg_shift_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_din = 1'b0, ser_csn = 1'b1;
    logic st_tach = 1'b0, st_therm = 1'b0, st_sync = 1'b0, st_zc = 1'b0;
    logic run_en, step_only, brake_on, speed_src, mon_out;
    logic [1:0] ilim_code, pole_code, mon_sel;
    logic [13:0] speed_word;

    int total = 0, bad = 0;
    logic [23:0] exp_q[$];
    logic [23:0] model = '0;
    logic [23:0] last_ok = '0;

    always #5 clk = ~clk;

    cfg_shift_port dut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Field decode written from the requirement text (R5, R6).
    task automatic check_word(input string tag, input logic [23:0] w);
        check({tag, " R5 run"}, 32'(run_en), 32'(w[0]));
        check({tag, " R5 step"}, 32'(step_only), 32'(w[1]));
        check({tag, " R5 brake"}, 32'(brake_on), 32'(w[2]));
        check({tag, " R6 ilim"}, 32'(ilim_code), 32'({w[3], w[4]}));
        check({tag, " R5 speed"}, 32'(speed_word), 32'(w[18:5]));
        check({tag, " R5 src"}, 32'(speed_src), 32'(w[19]));
        check({tag, " R6 pole"}, 32'(pole_code), 32'({w[20], w[21]}));
        check({tag, " R6 msel"}, 32'(mon_sel), 32'({w[22], w[23]}));
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic sbit(input logic b);
        ser_din = b;
        wait_clk(4);
        ser_clk = 1'b1;
        wait_clk(4);
        ser_clk = 1'b0;
        model = {model[22:0], b};
    endtask

    task automatic open_frame;
        ser_csn = 1'b0;
        wait_clk(4);
    endtask

    task automatic close_frame;
        wait_clk(4);
        ser_csn = 1'b1;
        wait_clk(8);
        exp_q.push_back(model);
        wait (exp_q.size() == 0);
        wait_clk(2);
    endtask

    task automatic send(input int nbits, input logic [31:0] v);
        open_frame();
        for (int i = nbits - 1; i >= 0; i--) sbit(v[i]);
        close_frame();
    endtask

    // Monitor: pop each expected word and compare away from the active edge.
    initial begin
        forever begin
            wait (exp_q.size() != 0);
            @(negedge clk);
            check_word("sb R3 R4", exp_q[0]);
            last_ok = exp_q[0];
            void'(exp_q.pop_front());
        end
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        wait_clk(150000);
        bad++;
        total++;
        $display("FAIL watchdog R0 act=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_clk(4);
        @(negedge clk);
        // R1: reset state is all zero and the run enable is low (sleep).
        check_word("reset R1", 24'h0);
        rst_n = 1'b1;
        wait_clk(4);

        send(24, 32'hA5C3_7E);
        send(24, 32'h5A_3C81);

        // R4: outputs hold during a transfer.
        open_frame();
        for (int i = 23; i >= 12; i--) sbit(1'b1);
        @(negedge clk);
        check_word("midframe R4", 24'h5A3C81);
        for (int i = 11; i >= 0; i--) sbit(1'b0);
        close_frame();

        // R2: activity while deselected is ignored; an empty pulse reloads the same word.
        for (int i = 0; i < 6; i++) begin
            ser_din = i[0];
            wait_clk(4);
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
        end
        @(negedge clk);
        check("idle R2 held", 32'(run_en), 32'(model[0]));
        open_frame();
        close_frame();

        // R8: short and long frames keep the last 24 bits.
        send(8, 32'h0000_00B7);
        send(30, 32'h2D5E_9A13);

        // R7: each select code with an isolating status pattern.
        for (int s = 0; s < 4; s++) begin
            send(24, {8'h0, s[0], s[1], 22'h15A5A5});
            st_tach = (s == 0); st_therm = (s == 1);
            st_sync = (s == 2); st_zc = (s == 3);
            wait_clk(2);
            @(negedge clk);
            check($sformatf("mux R7 sel=%0d hi", s), 32'(mon_out), 32'd1);
            {st_tach, st_therm, st_sync, st_zc} = ~{st_tach, st_therm, st_sync, st_zc};
            wait_clk(2);
            @(negedge clk);
            check($sformatf("mux R7 sel=%0d lo", s), 32'(mon_out), 32'd0);
        end

        // R9: reset mid-transfer discards the bits; an empty pulse latches zero.
        open_frame();
        for (int i = 0; i < 10; i++) sbit(1'b1);
        rst_n = 1'b0;
        ser_csn = 1'b1;
        wait_clk(4);
        @(negedge clk);
        check_word("midreset R1", 24'h0);
        rst_n = 1'b1;
        wait_clk(4);
        model = '0;
        open_frame();
        close_frame();
        @(negedge clk);
        check("after R9 word", 32'(last_ok), 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule